// File: doc/BRIEF.md
# DDR Burst Column Sequencer

This block turns one start column into the ordered series of column addresses that a DDR SDRAM burst visits. A small mode register holds the burst length code, the burst ordering bit and the CAS latency. When a start strobe arrives, the block captures the start column together with the current burst settings. It then presents one column per beat on a valid/ready output stream until the final beat has been taken.

The column stream follows valid/ready rules. `col_valid_o` rises on the cycle after a start. A beat is consumed on every rising edge where valid and `col_ready_i` are both high. While ready is low, the column, the last flag and valid stay unchanged. There is no back-pressure on the start side: a start is always accepted, and it overrides whatever burst is in progress. The stored CAS latency is brought out for neighbouring blocks.

A separate combinational helper uses the live mode settings to reorder eight captured data beats, so that they come out in the order the device delivers them for a given start column.

Top module: `ddr_burst_seq`

## Requirements
- R1: After reset, `col_valid_o` and `col_last_o` are 0 and the mode register holds 0, so `cas_lat_o` reads 0.
- R2: Mode bits [2:0] set the burst length. Code 1 gives 2 beats, code 2 gives 4 and code 3 gives 8. Code 0 is handled as 2 beats, and codes 4 to 7 are handled as 8 beats.
- R3: Mode bit 3 picks the ordering. When it is 1, beat i uses the low three start-column bits XOR i. When it is 0, beat i uses those bits plus i, wrapping modulo 8.
- R4: For a 4-beat burst, bit 2 of the generated low column is forced to 0. For a 2-beat burst, bits [2:1] are forced to 0.
- R5: Column bits from bit 3 upward are copied from the start column on every beat.
- R6: Beat 0 appears on `col_o` one cycle after `start_i`. The beat advances only on an edge where `col_valid_o` and `col_ready_i` are both high. Otherwise the column and the flags hold.
- R7: `col_last_o` is high exactly while the final beat is presented. Once that beat is taken, `col_valid_o` falls.
- R8: A start during an active burst restarts the sequence at beat 0 with the new column. A start takes priority over a same-cycle ready.
- R9: Burst length and ordering are captured at the start. A mode write during a burst does not change that burst. A start in the same cycle as a mode write uses the previous settings.
- R10: `cas_lat_o` equals mode bits [6:4], starting the cycle after the write.
- R11: Reorder output beat i equals input beat c(i), where c(i) is the R3/R4 column for start bits `reord_col_i` under the live mode settings. Output beats at or beyond the burst length are 0. Beat k occupies bits [k*DQ_W +: DQ_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_we_i | input | 1 | Mode register write enable |
| mr_wdata_i | input | 7 | Mode value: [6:4] CAS latency, [3] ordering, [2:0] length code |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| start_col_i | input | COL_W | Start column |
| col_ready_i | input | 1 | Consumer accepts the presented beat |
| col_o | output | COL_W | Column of the current beat |
| col_valid_o | output | 1 | A beat is presented |
| col_last_o | output | 1 | The presented beat is the final one |
| cas_lat_o | output | 3 | Stored CAS latency |
| reord_col_i | input | 3 | Low start-column bits for the reorder helper |
| reord_data_i | input | 8*DQ_W | Eight captured beats, beat 0 lowest |
| reord_data_o | output | 8*DQ_W | Beats in device order |

## Verification
The bench aims at wrap behaviour. It uses sequential starts near the top of the three-bit field, where an adder without the wrap would corrupt bit 3 and above and miss R5. It also covers short bursts whose start column has bits 2 or 1 set, where missing masking would emit columns outside the burst window. It stalls the stream to catch a design that advances without ready. It restarts a burst mid-flight while ready is high to catch one that lets the advance win. It writes the mode register both during a burst and in the same cycle as a start, where a design reading the live register would change its length or ordering mid-burst.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

  localparam int BEAT_MAX = 8;
  localparam int BEAT_W   = $clog2(BEAT_MAX);
  localparam int MODE_W   = 7;

  typedef enum logic [1:0] {
    LEN2 = 2'd0,
    LEN4 = 2'd1,
    LEN8 = 2'd2
  } burst_len_e;

  // Length code to burst size; code 0 folds to the shortest, reserved high codes to the longest.
  function automatic burst_len_e decode_len(input logic [2:0] code);
    burst_len_e l;
    case (code)
      3'd0, 3'd1: l = LEN2;
      3'd2:       l = LEN4;
      default:    l = LEN8;
    endcase
    return l;
  endfunction

  function automatic logic [BEAT_W-1:0] final_beat(input burst_len_e l);
    logic [BEAT_W-1:0] r;
    case (l)
      LEN2:    r = BEAT_W'(1);
      LEN4:    r = BEAT_W'(3);
      default: r = BEAT_W'(7);
    endcase
    return r;
  endfunction

  // Low column bits of one beat: XOR or wrapping add, then window masking.
  function automatic logic [BEAT_W-1:0] beat_col(input logic [BEAT_W-1:0] s,
                                                 input logic [BEAT_W-1:0] i,
                                                 input burst_len_e        l,
                                                 input logic              ilv);
    logic [BEAT_W-1:0] r;
    r = ilv ? (s ^ i) : BEAT_W'(s + i);
    case (l)
      LEN2:    r[2:1] = 2'b00;
      LEN4:    r[2]   = 1'b0;
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ddr_burst_mode_reg.sv
module ddr_burst_mode_reg
  import ddr_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output burst_len_e        len_o,
  output logic              ilv_o,
  output logic [2:0]        cas_lat_o
);

  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mode_q <= '0;
    else if (we_i) mode_q <= wdata_i;
  end

  always_comb begin
    len_o     = decode_len(mode_q[2:0]);
    ilv_o     = mode_q[3];
    cas_lat_o = mode_q[6:4];
  end

  // R10: latency follows the written field one cycle later
  p_cl_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cas_lat_o == $past(wdata_i[6:4])));

endmodule

// File: rtl/ddr_burst_col_gen.sv
module ddr_burst_col_gen
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 10
)(
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_len_e        len_i,
  input  logic              ilv_i,
  output logic [COL_W-1:0]  col_o
);

  localparam int HI_W = COL_W - BEAT_W;

  logic [HI_W-1:0]   hi;
  logic [BEAT_W-1:0] lo;

  always_comb begin
    hi    = base_i[COL_W-1:BEAT_W];
    lo    = beat_col(base_i[BEAT_W-1:0], beat_i, len_i, ilv_i);
    col_o = {hi, lo};
  end

endmodule

// File: rtl/ddr_burst_reorder.sv
module ddr_burst_reorder
  import ddr_burst_pkg::*;
#(
  parameter int DQ_W = 8
)(
  input  logic [BEAT_W-1:0]        scol_i,
  input  burst_len_e               len_i,
  input  logic                     ilv_i,
  input  logic [BEAT_MAX*DQ_W-1:0] data_i,
  output logic [BEAT_MAX*DQ_W-1:0] data_o
);

  logic [BEAT_W-1:0] count_m1;
  assign count_m1 = final_beat(len_i);

  for (genvar g = 0; g < BEAT_MAX; g++) begin : g_beat
    logic [BEAT_W-1:0] src;
    always_comb begin
      src = beat_col(scol_i, BEAT_W'(g), len_i, ilv_i);
      if (BEAT_W'(g) <= count_m1)
        data_o[g*DQ_W +: DQ_W] = data_i[src*DQ_W +: DQ_W];
      else
        data_o[g*DQ_W +: DQ_W] = '0;
    end
  end

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int DQ_W  = 8
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mr_we_i,
  input  logic [6:0]               mr_wdata_i,
  input  logic                     start_i,
  input  logic [COL_W-1:0]         start_col_i,
  input  logic                     col_ready_i,
  output logic [COL_W-1:0]         col_o,
  output logic                     col_valid_o,
  output logic                     col_last_o,
  output logic [2:0]               cas_lat_o,
  input  logic [2:0]               reord_col_i,
  input  logic [8*DQ_W-1:0]        reord_data_i,
  output logic [8*DQ_W-1:0]        reord_data_o
);

  burst_len_e        mode_len;
  logic              mode_ilv;

  logic              valid_q;
  logic [BEAT_W-1:0] beat_q;
  logic [COL_W-1:0]  base_q;
  burst_len_e        len_q;
  logic              ilv_q;
  logic              at_end;
  logic              take;

  ddr_burst_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (mr_we_i),
    .wdata_i   (mr_wdata_i),
    .len_o     (mode_len),
    .ilv_o     (mode_ilv),
    .cas_lat_o (cas_lat_o)
  );

  assign at_end = (beat_q == final_beat(len_q));
  assign take   = valid_q && col_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      len_q   <= LEN2;
      ilv_q   <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      beat_q  <= '0;
      base_q  <= start_col_i;
      len_q   <= mode_len;
      ilv_q   <= mode_ilv;
    end else if (take) begin
      if (at_end) valid_q <= 1'b0;
      else        beat_q  <= beat_q + 1'b1;
    end
  end

  ddr_burst_col_gen #(.COL_W(COL_W)) u_col (
    .base_i (base_q),
    .beat_i (beat_q),
    .len_i  (len_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign col_valid_o = valid_q;
  assign col_last_o  = valid_q && at_end;

  ddr_burst_reorder #(.DQ_W(DQ_W)) u_reord (
    .scol_i (reord_col_i),
    .len_i  (mode_len),
    .ilv_i  (mode_ilv),
    .data_i (reord_data_i),
    .data_o (reord_data_o)
  );

  // R6: a stalled beat is held
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && !col_ready_i && !start_i) |=>
      (col_valid_o && $stable(col_o) && $stable(col_last_o)));

  // R7: last only with valid
  p_last_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_last_o |-> col_valid_o);

  // R7: taking the last beat ends the burst
  p_end_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last_o && col_ready_i && !start_i) |=> !col_valid_o);

  // R8 and R5: a start always yields a beat carrying the new upper column bits
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (col_valid_o &&
                 col_o[COL_W-1:BEAT_W] == $past(start_col_i[COL_W-1:BEAT_W])));

  // R2: beat index never runs past the captured length
  p_beat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o |-> (beat_q <= final_beat(len_q)));

endmodule

// File: tb/ddr_burst_seq_tb_top.sv
module ddr_burst_seq_tb_top;

  localparam int COL_W = 10;
  localparam int DQ_W  = 8;

  typedef struct packed {
    logic [2:0]  code;
    logic        bt;
    logic [9:0]  scol;
    logic [3:0]  n;
    logic [79:0] cols;
  } vec_t;

  // Expected columns: beat k in cols[k*10 +: 10]
  localparam vec_t VECS [8] = '{
    '{3'd3, 1'b0, 10'h2A5, 4'd8, {10'h2A4,10'h2A3,10'h2A2,10'h2A1,10'h2A0,10'h2A7,10'h2A6,10'h2A5}},
    '{3'd3, 1'b1, 10'h2A5, 4'd8, {10'h2A2,10'h2A3,10'h2A0,10'h2A1,10'h2A6,10'h2A7,10'h2A4,10'h2A5}},
    '{3'd2, 1'b0, 10'h13E, 4'd4, {40'h0,10'h139,10'h138,10'h13B,10'h13A}},
    '{3'd2, 1'b1, 10'h13D, 4'd4, {40'h0,10'h13A,10'h13B,10'h138,10'h139}},
    '{3'd1, 1'b0, 10'h0FF, 4'd2, {60'h0,10'h0F8,10'h0F9}},
    '{3'd1, 1'b1, 10'h002, 4'd2, {60'h0,10'h001,10'h000}},
    '{3'd5, 1'b0, 10'h001, 4'd8, {10'h000,10'h007,10'h006,10'h005,10'h004,10'h003,10'h002,10'h001}},
    '{3'd0, 1'b0, 10'h3FB, 4'd2, {60'h0,10'h3F8,10'h3F9}}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mr_we = 1'b0;
  logic [6:0]       mr_wdata = '0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             ready = 1'b0;
  logic [COL_W-1:0] col;
  logic             valid;
  logic             last;
  logic [2:0]       cas_lat;
  logic [2:0]       reord_col = '0;
  logic [8*DQ_W-1:0] reord_in = '0;
  logic [8*DQ_W-1:0] reord_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ddr_burst_seq #(.COL_W(COL_W), .DQ_W(DQ_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mr_we_i      (mr_we),
    .mr_wdata_i   (mr_wdata),
    .start_i      (start),
    .start_col_i  (start_col),
    .col_ready_i  (ready),
    .col_o        (col),
    .col_valid_o  (valid),
    .col_last_o   (last),
    .cas_lat_o    (cas_lat),
    .reord_col_i  (reord_col),
    .reord_data_i (reord_in),
    .reord_data_o (reord_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] mode(input logic [2:0] cl, input logic bt, input logic [2:0] code);
    return {cl, bt, code};
  endfunction

  task automatic write_mode(input logic [6:0] v);
    mr_we = 1'b1; mr_wdata = v;
    @(negedge clk);
    mr_we = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", valid, 0);
    chk("R1 last", last, 0);
    chk("R1 cas", cas_lat, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < 8; v++) begin
      write_mode(mode(3'd0, VECS[v].bt, VECS[v].code));
      start = 1'b1; start_col = VECS[v].scol; ready = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int b = 0; b < int'(VECS[v].n); b++) begin
        chk($sformatf("R3/R4/R5 vec%0d beat%0d col", v, b), col, VECS[v].cols[b*10 +: 10]);
        chk($sformatf("R2 vec%0d beat%0d valid", v, b), valid, 1);
        chk($sformatf("R7 vec%0d beat%0d last", v, b), last, (b == int'(VECS[v].n) - 1));
        @(negedge clk);
      end
      chk($sformatf("R7 vec%0d valid drop", v), valid, 0);
      ready = 1'b0;
    end

    // R6 back-pressure
    write_mode(mode(3'd0, 1'b0, 3'd3));
    start = 1'b1; start_col = 10'h010; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R6 first beat", col, 10'h010);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 stalled col", col, 10'h010);
      chk("R6 stalled valid", valid, 1);
    end
    ready = 1'b1;
    @(negedge clk);
    chk("R6 advance", col, 10'h011);

    // R8 restart with ready high
    start = 1'b1; start_col = 10'h205;
    @(negedge clk);
    start = 1'b0;
    chk("R8 restart col", col, 10'h205);
    chk("R8 restart last", last, 0);

    // R9 mode write mid-burst, R10 latency
    write_mode(mode(3'd5, 1'b1, 3'd1));
    chk("R9 mid-burst col", col, 10'h206);
    chk("R10 cas", cas_lat, 5);
    @(negedge clk);
    chk("R9 mid-burst col2", col, 10'h207);
    chk("R9 mid-burst last", last, 0);
    for (int k = 0; k < 8 && valid; k++) @(negedge clk);
    chk("R9 burst ended", valid, 0);

    // R9 start together with mode write uses the old settings (2 beats, interleaved)
    ready = 1'b0;
    mr_we = 1'b1; mr_wdata = mode(3'd0, 1'b0, 3'd3);
    start = 1'b1; start_col = 10'h000;
    @(negedge clk);
    mr_we = 1'b0; start = 1'b0; ready = 1'b1;
    chk("R9 same-cycle beat0", col, 10'h000);
    @(negedge clk);
    chk("R9 same-cycle beat1", col, 10'h001);
    chk("R9 same-cycle last", last, 1);
    @(negedge clk);
    chk("R9 same-cycle end", valid, 0);
    ready = 1'b0;

    // R11 reorder helper
    reord_in = {8'h17,8'h16,8'h15,8'h14,8'h13,8'h12,8'h11,8'h10};
    write_mode(mode(3'd0, 1'b1, 3'd3));
    reord_col = 3'd5;
    #1;
    chk("R11 interleaved 8", reord_out, {8'h12,8'h13,8'h10,8'h11,8'h16,8'h17,8'h14,8'h15});
    write_mode(mode(3'd0, 1'b0, 3'd2));
    reord_col = 3'd2;
    #1;
    chk("R11 sequential 4", reord_out, {32'h0,8'h11,8'h10,8'h13,8'h12});

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule